// File: doc/BRIEF.md
# ECP Reverse-Channel Byte Receiver

This block is the host side of the reverse direction of an IEEE 1284 ECP link, where the peripheral sends bytes to the host. After a start request with a byte count, it turns off the host data-bus drivers. It then runs the two-step handshake for each byte. First the peripheral lowers its strobe, with its reverse-acknowledge low and its flag high, and the host answers by raising its acknowledge. Then the peripheral raises its strobe again, and the host latches the data bus and drops its acknowledge. Each received byte leaves the block on a one-cycle valid strobe. There is no backpressure.

The transfer ends when the requested number of bytes has arrived, or when a handshake wait runs past its limit. A completed transfer leaves the link phase at reverse-idle. A failed transfer leaves it at unknown. In both cases the data-bus drivers are enabled again and the count of bytes received is held on `byte_cnt`. The wait for the first byte of a transfer gets a long limit, so the peripheral has time to start. Later bytes get the long limit only while the fault line is low, and every other wait uses a short limit. All peripheral control lines pass through a two-flop synchroniser before the handshake logic uses them. Turning the link direction around is outside this block.

Top module: `ecp_rev_rx`

## Requirements
- R1: After reset, `bus_oe`=1, `host_ack`=0, `busy`=0, `rx_valid`=0 and `phase`=0 (idle). Phase codes are 0 idle, 1 transferring, 2 reverse-idle and 3 unknown.
- R2: A `start` with nonzero `req_len` makes `busy`=1, `bus_oe`=0 and `phase`=1, and `bus_oe` stays 0 for as long as `busy` is 1.
- R3: `host_ack` rises only after the synchronised `periph_clk_n` is low, `ack_rev_n` is low and `xflag` is high. While `xflag` is low, `host_ack` stays 0.
- R4: `host_ack` falls once the synchronised `periph_clk_n` is high, with `ack_rev_n` low and `xflag` high. In the same cycle `rx_data` shows the byte on `pd_in` and `rx_valid` is high for exactly one cycle. Bytes come out in arrival order.
- R5: After `req_len` bytes, `done` pulses for one cycle, `busy`=0, `bus_oe`=1, `phase`=2 and `byte_cnt`=`req_len`.
- R6: The wait for the strobe to go low lasts `LONG_TO` cycles for the first byte, or while `fault_n` is low. All other waits last `SHORT_TO` cycles.
- R7: When a wait expires, `err` pulses for one cycle, `phase`=3, `bus_oe`=1 and `host_ack`=0, and `byte_cnt` holds the number of bytes completed.
- R8: A `start` with `req_len`=0 gives a `done` pulse in the next cycle with `phase`=2, no `rx_valid` and `byte_cnt`=0.
- R9: A `start` pulse while `busy` has no effect: the transfer finishes with its original length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a reverse transfer (ignored while busy) |
| req_len | input | CNT_W | Number of bytes to receive |
| pd_in | input | DW | Data bus as seen by the host |
| periph_clk_n | input | 1 | Peripheral strobe, low = byte offered |
| ack_rev_n | input | 1 | Peripheral reverse acknowledge, low in reverse |
| xflag | input | 1 | Peripheral extensibility flag, high for ECP |
| fault_n | input | 1 | Peripheral fault, low selects the long limit |
| host_ack | output | 1 | Host acknowledge to the peripheral |
| bus_oe | output | 1 | Host data-bus driver enable (0 = floated) |
| rx_data | output | DW | Received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse on completion |
| err | output | 1 | One-cycle pulse on timeout |
| byte_cnt | output | CNT_W | Bytes received in the current or last transfer |
| phase | output | 2 | Link phase code |

## Verification
A table of transfers with lengths 1, 2, 3 and 6 and different data patterns drives a handshake-obeying peripheral model. Each row shows whether bytes are lost, repeated or reordered, and whether the count stops at the right value. Timeouts are provoked at four points, and the measured cycles to `err` separate the long limit from the short one. The four points are a silent first byte, a silent second byte, a silent second byte with the fault line low, and a strobe that never returns high. A zero-length start, a transfer with the flag held low and a start during a transfer cover the edge cases.

// File: rtl/ecp_rev_rx.sv
`timescale 1ns/1ps
module ecp_rev_rx #(
  parameter int DW       = 8,
  parameter int CNT_W    = 16,
  parameter int LONG_TO  = 50000,
  parameter int SHORT_TO = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] req_len,
  input  logic [DW-1:0]    pd_in,
  input  logic             periph_clk_n,
  input  logic             ack_rev_n,
  input  logic             xflag,
  input  logic             fault_n,
  output logic             host_ack,
  output logic             bus_oe,
  output logic [DW-1:0]    rx_data,
  output logic             rx_valid,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [CNT_W-1:0] byte_cnt,
  output logic [1:0]       phase
);
  localparam int TW = $clog2(LONG_TO + 1);
  localparam logic [1:0] PH_IDLE = 2'd0, PH_XFER = 2'd1, PH_RIDLE = 2'd2, PH_UNK = 2'd3;
  localparam logic [TW-1:0] LIM_LONG  = TW'(LONG_TO - 1);
  localparam logic [TW-1:0] LIM_SHORT = TW'(SHORT_TO - 1);

  typedef enum logic [1:0] {S_IDLE, S_WLO, S_WHI} st_t;
  st_t st;

  // {strobe, reverse-ack, flag, fault}
  logic [3:0] sy1, sy2;
  logic [TW-1:0] tmr;
  logic [CNT_W-1:0] len_q;

  wire s_clk = sy2[3];
  wire s_ar  = sy2[2];
  wire s_xf  = sy2[1];
  wire s_ft  = sy2[0];
  wire lo_ok = !s_clk && !s_ar && s_xf;
  wire hi_ok = s_clk && !s_ar && s_xf;
  wire [TW-1:0] lim_lo = (byte_cnt == '0 || !s_ft) ? LIM_LONG : LIM_SHORT;
  wire [CNT_W-1:0] cnt_nx = byte_cnt + 1'b1;

  assign busy     = (st != S_IDLE);
  assign bus_oe   = !busy;
  assign host_ack = (st == S_WHI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1 <= 4'b1101;
      sy2 <= 4'b1101;
    end else begin
      sy1 <= {periph_clk_n, ack_rev_n, xflag, fault_n};
      sy2 <= sy1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tmr      <= '0;
      len_q    <= '0;
      byte_cnt <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      phase    <= PH_IDLE;
    end else begin
      rx_valid <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          len_q    <= req_len;
          byte_cnt <= '0;
          tmr      <= '0;
          if (req_len == '0) begin
            done  <= 1'b1;
            phase <= PH_RIDLE;
          end else begin
            st    <= S_WLO;
            phase <= PH_XFER;
          end
        end
        S_WLO: begin
          if (lo_ok) begin
            st  <= S_WHI;
            tmr <= '0;
          end else if (tmr >= lim_lo) begin
            st    <= S_IDLE;
            err   <= 1'b1;
            phase <= PH_UNK;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_WHI: begin
          if (hi_ok) begin
            rx_data  <= pd_in;
            rx_valid <= 1'b1;
            byte_cnt <= cnt_nx;
            tmr      <= '0;
            if (cnt_nx == len_q) begin
              st    <= S_IDLE;
              done  <= 1'b1;
              phase <= PH_RIDLE;
            end else begin
              st <= S_WLO;
            end
          end else if (tmr >= LIM_SHORT) begin
            st    <= S_IDLE;
            err   <= 1'b1;
            phase <= PH_UNK;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_FLOAT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !bus_oe); // R2
  AST_ACK_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_ack) |-> (!$past(periph_clk_n, 3) && !$past(ack_rev_n, 3) && $past(xflag, 3))); // R3
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid); // R4
  AST_DONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (phase == PH_RIDLE && bus_oe && byte_cnt == len_q)); // R5
  AST_ERR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (phase == PH_UNK && bus_oe && !host_ack)); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy |-> byte_cnt < len_q); // R5
  AST_START_IGN: assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> $stable(len_q)); // R9
endmodule

// File: tb/ecp_rev_rx_bench.sv
`timescale 1ns/1ps
module ecp_rev_rx_bench;
  localparam int LT = 200, ST = 40;
  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] req_len = 0;
  logic [7:0] pd_in = 0;
  logic periph_clk_n = 1, ack_rev_n = 1, xflag = 0, fault_n = 1;
  logic host_ack, bus_oe, rx_valid, busy, done, err;
  logic [7:0] rx_data;
  logic [15:0] byte_cnt;
  logic [1:0] phase;
  int total = 0, bad = 0;
  logic [7:0] got [16];
  int ngot = 0, ndone = 0;

  always #2.5 clk = ~clk;

  ecp_rev_rx #(.DW(8), .CNT_W(16), .LONG_TO(LT), .SHORT_TO(ST)) u_ecp_rev_rx (
    .clk(clk), .rst_n(rst_n), .start(start), .req_len(req_len), .pd_in(pd_in),
    .periph_clk_n(periph_clk_n), .ack_rev_n(ack_rev_n), .xflag(xflag), .fault_n(fault_n),
    .host_ack(host_ack), .bus_oe(bus_oe), .rx_data(rx_data), .rx_valid(rx_valid),
    .busy(busy), .done(done), .err(err), .byte_cnt(byte_cnt), .phase(phase));

  always @(negedge clk) begin
    if (rx_valid && ngot < 16) begin got[ngot] = rx_data; ngot++; end
    if (done) ndone++;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go(input int len);
    @(negedge clk); req_len = 16'(len); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic send(input logic [7:0] d, output bit ok);
    int n;
    ok = 0;
    pd_in = d; periph_clk_n = 0;
    n = 0;
    while (!host_ack && n < 100) begin @(negedge clk); n++; end
    if (!host_ack) begin periph_clk_n = 1; return; end
    periph_clk_n = 1;
    n = 0;
    while (host_ack && n < 100) begin @(negedge clk); n++; end
    ok = !host_ack;
  endtask

  task automatic wait_err(output int n);
    n = 0;
    while (!err && n < 1000) begin @(negedge clk); n++; end
  endtask

  function automatic bit near(int a, int b);
    return (a >= b - 5) && (a <= b + 5);
  endfunction

  // {length, seed, step}
  localparam logic [23:0] VEC [4] = '{ {8'd1, 8'h5A, 8'd0}, {8'd3, 8'hA0, 8'd17},
                                       {8'd6, 8'hFF, 8'd37}, {8'd2, 8'h00, 8'd128} };

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ok, saw_ack;
    int n, ng0, nd0;
    repeat (3) @(negedge clk);
    chk("R1 bus_oe", bus_oe, 1); chk("R1 host_ack", host_ack, 0);
    chk("R1 busy", busy, 0); chk("R1 phase", phase, 0); chk("R1 rx_valid", rx_valid, 0);
    rst_n = 1; ack_rev_n = 0; xflag = 1;
    repeat (3) @(negedge clk);

    foreach (VEC[r]) begin
      int len = int'(VEC[r][23:16]);
      ng0 = ngot; nd0 = ndone;
      go(len);
      chk("R2 busy", busy, 1); chk("R2 bus_oe", bus_oe, 0); chk("R2 phase", phase, 1);
      for (int i = 0; i < len; i++) begin
        send(8'(VEC[r][15:8] + 8'(i) * VEC[r][7:0]), ok);
        chk("R4 handshake", ok, 1);
      end
      repeat (2) @(negedge clk);
      chk("R4 byte count out", ngot - ng0, len);
      for (int i = 0; i < len; i++)
        chk("R4 data order", got[ng0 + i], int'(8'(VEC[r][15:8] + 8'(i) * VEC[r][7:0])));
      chk("R5 done", ndone - nd0, 1); chk("R5 busy", busy, 0);
      chk("R5 bus_oe", bus_oe, 1); chk("R5 phase", phase, 2); chk("R5 byte_cnt", byte_cnt, len);
    end

    // zero length
    ng0 = ngot;
    @(negedge clk); req_len = 0; start = 1;
    @(negedge clk); start = 0;
    chk("R8 done", done, 1); chk("R8 phase", phase, 2); chk("R8 byte_cnt", byte_cnt, 0);
    repeat (2) @(negedge clk);
    chk("R8 no data", ngot - ng0, 0);

    // first byte silent: long limit
    go(2); wait_err(n);
    chk("R6 first byte long limit", near(n, LT), 1);
    chk("R7 phase", phase, 3); chk("R7 bus_oe", bus_oe, 1);
    chk("R7 host_ack", host_ack, 0); chk("R7 count", byte_cnt, 0);
    repeat (4) @(negedge clk);

    // second byte silent: short limit
    go(3); send(8'h11, ok); wait_err(n);
    chk("R6 later byte short limit", near(n, ST), 1);
    chk("R7 partial count", byte_cnt, 1); chk("R7 phase unk", phase, 3);
    repeat (4) @(negedge clk);

    // fault low: long limit for second byte
    fault_n = 0;
    go(3); send(8'h22, ok); wait_err(n);
    chk("R6 fault long limit", near(n, LT), 1);
    fault_n = 1;
    repeat (4) @(negedge clk);

    // strobe never returns high
    go(2); periph_clk_n = 0;
    n = 0; while (!host_ack && n < 50) begin @(negedge clk); n++; end
    chk("R3 ack after strobe", host_ack, 1);
    wait_err(n);
    chk("R6 high wait short", near(n, ST), 1);
    chk("R7 ack dropped", host_ack, 0); chk("R7 count zero", byte_cnt, 0);
    periph_clk_n = 1;
    repeat (4) @(negedge clk);

    // flag low blocks handshake
    xflag = 0; saw_ack = 0;
    go(1); periph_clk_n = 0;
    n = 0;
    while (!err && n < 1000) begin saw_ack |= host_ack; @(negedge clk); n++; end
    chk("R3 no ack with flag low", saw_ack, 0); chk("R3 err with flag low", phase, 3);
    periph_clk_n = 1; xflag = 1;
    repeat (4) @(negedge clk);

    // start during transfer ignored
    nd0 = ndone;
    go(2); send(8'h33, ok);
    @(negedge clk); req_len = 5; start = 1; @(negedge clk); start = 0;
    send(8'h44, ok);
    repeat (2) @(negedge clk);
    chk("R9 original length", byte_cnt, 2); chk("R9 done once", ndone - nd0, 1);
    chk("R9 idle after", busy, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule